// File: doc/BRIEF.md
# Key-Protected External Reset Pulse Generator

This block produces the external reset pulse that a watchdog raises when it expires. The watchdog core gives a one-cycle trigger strobe. The block then holds an output pulse for a programmable number of microsecond ticks, and the core supplies those ticks as a 1 MHz enable strobe. The duration sits in a 20-bit field of a 32-bit configuration word. A value of N in that field gives a pulse of N+1 ticks.

Two flags in the same word pick the pulse polarity and the way the line is driven. Neither flag changes on an ordinary write. Each changes only when one of four key bytes sits in the top byte of a write. Any write still stores the duration field, whatever the top byte holds. In open-drain mode the line is driven only while the pulse is active, which emulates a wired reset net. In push-pull mode the line is driven at all times.

Top module: `rstp_pulse_gen`

## Requirements
- R1: After reset the configuration word reads 0x000000FF, which means a 256-tick duration, active-low polarity and open-drain drive. The pulse is inactive, so `pulse_out` is 1 and `pulse_oe` is 0.
- R2: Every write stores `wr_data[19:0]` as the duration field, whatever the top byte holds. The field reads back on `rd_data[19:0]` from the cycle after the write.
- R3: The polarity flag reads on `rd_data[31]`, with 1 for active-high. A write whose top byte `wr_data[31:24]` is 0xA5 sets the flag, and one whose top byte is 0x5A clears it. Every other top byte leaves the flag unchanged.
- R4: The drive flag reads on `rd_data[30]`, with 1 for push-pull. A top byte of 0xA8 sets the flag, 0x8A clears it, and every other top byte leaves it unchanged.
- R5: `rd_data[29:20]` always reads as zero.
- R6: A trigger with duration field N starts a pulse that ends on the (N+1)th tick after the trigger. Cycles without a tick do not advance the count.
- R7: A trigger that arrives during a pulse reloads the count from the duration field, so the pulse then lasts N+1 ticks from the new trigger. If a trigger and a tick fall in the same cycle, the trigger wins.
- R8: In push-pull mode `pulse_oe` is always 1. `pulse_out` equals the polarity flag while the pulse is active and its inverse otherwise.
- R9: In open-drain mode `pulse_oe` is 1 only while the pulse is active. `pulse_out` still shows the active level during the pulse and the inactive level outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data: key byte in [31:24], duration in [19:0] |
| rd_data | output | 32 | Configuration word readback |
| trigger | input | 1 | One-cycle strobe from the watchdog core that starts or restarts the pulse |
| tick | input | 1 | Microsecond tick enable |
| pulse_out | output | 1 | Pulse level with the chosen polarity |
| pulse_oe | output | 1 | Output enable for the pad |

## Verification
A wrong key decode shows up on the cycle after the offending write. Either a flag on `rd_data[31:30]` flips on a byte that is not a key, or it stays put on a byte that is a key. Sweeping all 256 top-byte values from both flag states exposes this at once. A count that is off by one, or a reload that is lost, shows in the length of the pulse, measured in cycles at `pulse_oe`/`pulse_out`. It appears as soon as the pulse ends, and it scales with the tick period. A swapped polarity or drive decision shows in the idle levels before any trigger is given.

// File: rtl/rstp_pkg.sv
package rstp_pkg;

  localparam int DUR_BITS = 20;
  localparam int WORD_BITS = 32;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef struct packed {
    logic pol_high;
    logic push_pull;
  } drive_cfg_t;

  // Flag update from a key byte: set key, clear key, or hold.
  function automatic logic keyed_flag(input logic [7:0] key, input logic cur,
                                      input logic [7:0] set_key,
                                      input logic [7:0] clr_key);
    if (key == set_key) return 1'b1;
    if (key == clr_key) return 1'b0;
    return cur;
  endfunction

  // Pack the readback word; bits between the flags and the field are zero.
  function automatic logic [WORD_BITS-1:0] pack_word(input drive_cfg_t cfg,
                                                     input logic [DUR_BITS-1:0] dur);
    logic [WORD_BITS-1:0] w;
    w = '0;
    w[WORD_BITS-1] = cfg.pol_high;
    w[WORD_BITS-2] = cfg.push_pull;
    w[DUR_BITS-1:0] = dur;
    return w;
  endfunction

endpackage

// File: rtl/rstp_cfg_reg.sv
module rstp_cfg_reg
  import rstp_pkg::*;
#(
  parameter logic [DUR_BITS-1:0] DUR_RESET = 20'h000FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WORD_BITS-1:0] wr_data,
  output logic [DUR_BITS-1:0]  dur_q,
  output drive_cfg_t           cfg_q,
  output logic                 pol_key_hit,
  output logic                 drv_key_hit
);

  localparam int KEY_LSB = WORD_BITS - 8;

  logic [7:0] key_byte;
  logic       unused_mid;
  drive_cfg_t cfg_next;

  assign key_byte   = wr_data[WORD_BITS-1:KEY_LSB];
  assign unused_mid = ^wr_data[KEY_LSB-1:DUR_BITS];

  assign pol_key_hit = wr_en && (key_byte == KEY_POL_HIGH || key_byte == KEY_POL_LOW);
  assign drv_key_hit = wr_en && (key_byte == KEY_DRV_PP || key_byte == KEY_DRV_OD);

  always_comb begin
    cfg_next.pol_high  = keyed_flag(key_byte, cfg_q.pol_high, KEY_POL_HIGH, KEY_POL_LOW);
    cfg_next.push_pull = keyed_flag(key_byte, cfg_q.push_pull, KEY_DRV_PP, KEY_DRV_OD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q <= DUR_RESET;
      cfg_q <= '0;
    end else if (wr_en) begin
      dur_q <= wr_data[DUR_BITS-1:0];
      cfg_q <= cfg_next;
    end
  end

endmodule

// File: rtl/rstp_width_timer.sv
module rstp_width_timer
  import rstp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trigger,
  input  logic                tick,
  input  logic [DUR_BITS-1:0] dur,
  output logic                active,
  output logic                count_zero
);

  logic [DUR_BITS-1:0] remain;

  assign count_zero = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (trigger) begin
      active <= 1'b1;
      remain <= dur;
    end else if (active && tick) begin
      if (count_zero) active <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/rstp_pad_drive.sv
module rstp_pad_drive
  import rstp_pkg::*;
(
  input  logic       active,
  input  drive_cfg_t cfg,
  output logic       pulse_out,
  output logic       pulse_oe
);

  assign pulse_out = active ? cfg.pol_high : ~cfg.pol_high;
  assign pulse_oe  = cfg.push_pull | active;

endmodule

// File: rtl/rstp_pulse_gen.sv
module rstp_pulse_gen
  import rstp_pkg::*;
#(
  parameter logic [DUR_BITS-1:0] DUR_RESET = 20'h000FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        trigger,
  input  logic        tick,
  output logic        pulse_out,
  output logic        pulse_oe
);

  logic [DUR_BITS-1:0] dur_q;
  drive_cfg_t          cfg_q;
  logic                pol_key_hit;
  logic                drv_key_hit;
  logic                pulse_active;
  logic                count_zero;

  rstp_cfg_reg #(.DUR_RESET(DUR_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dur_q(dur_q), .cfg_q(cfg_q),
    .pol_key_hit(pol_key_hit), .drv_key_hit(drv_key_hit)
  );

  rstp_width_timer u_timer (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .tick(tick),
    .dur(dur_q), .active(pulse_active), .count_zero(count_zero)
  );

  rstp_pad_drive u_pad (
    .active(pulse_active), .cfg(cfg_q),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  assign rd_data = pack_word(cfg_q, dur_q);

endmodule

// File: rtl/rstp_checker.sv
module rstp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        trigger,
  input logic        tick,
  input logic        pulse_out,
  input logic        pulse_oe,
  input logic        pulse_active,
  input logic        count_zero,
  input logic        pol_key_hit,
  input logic        drv_key_hit
);

  p_width_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[19:0] == $past(wr_data[19:0]));

  p_pol_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_key_hit |=> $stable(rd_data[31]));

  p_drv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_key_hit |=> $stable(rd_data[30]));

  p_mid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[29:20] == 10'd0);

  p_end_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active && tick && count_zero && !trigger |=> !pulse_active);

  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active && !tick && !trigger |=> pulse_active);

  p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_active && !trigger |=> !pulse_active);

  p_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> pulse_active);

  p_pushpull_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[30] |-> pulse_oe);

  p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out == (pulse_active == rd_data[31]));

  p_opendrain_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[30] |-> pulse_oe == pulse_active);

endmodule

bind rstp_pulse_gen rstp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .trigger(trigger), .tick(tick),
  .pulse_out(pulse_out), .pulse_oe(pulse_oe),
  .pulse_active(pulse_active), .count_zero(count_zero),
  .pol_key_hit(pol_key_hit), .drv_key_hit(drv_key_hit)
);

// File: tb/rstp_pulse_gen_test.sv
`timescale 1ns/1ps
module rstp_pulse_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        trigger = 1'b0;
  logic        tick = 1'b0;
  logic        pulse_out;
  logic        pulse_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit m_pol = 0;
  bit m_drv = 0;

  always #5 clk = ~clk;

  rstp_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trigger(trigger), .tick(tick),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
    // model of the key rules
    if (d[31:24] == 8'hA5) m_pol = 1;
    else if (d[31:24] == 8'h5A) m_pol = 0;
    if (d[31:24] == 8'hA8) m_drv = 1;
    else if (d[31:24] == 8'h8A) m_drv = 0;
  endtask

  function automatic logic [31:0] exp_word(input logic [19:0] dur);
    return {m_pol, m_drv, 10'd0, dur};
  endfunction

  // asserted = line driven at the active level
  function automatic bit asserted();
    return pulse_oe && (pulse_out == m_pol);
  endfunction

  task automatic idle_check(input string req);
    check(req, {31'd0, pulse_out}, {31'd0, ~m_pol});
    check(req, {31'd0, pulse_oe}, {31'd0, m_drv});
  endtask

  // Count cycles the line is asserted after a trigger; ticks every per cycles.
  task automatic measure(input int per, output int len);
    int k;
    len = 0;
    k = 1;
    trigger = 1'b1;
    step();
    trigger = 1'b0;
    while (asserted() && k < 5000) begin
      tick = (k % per == 0);
      len++;
      step();
      k++;
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 word", rd_data, 32'h000000FF);
    check("R1 out", {31'd0, pulse_out}, 32'd1);
    check("R1 oe", {31'd0, pulse_oe}, 32'd0);

    // R2 R3 R4 R5: sweep every top byte from both flag states
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 0) begin wr(32'hA5000000); wr(32'hA8000000); end
      else begin wr(32'h5A000000); wr(32'h8A000000); end
      for (int b = 0; b < 256; b++) begin
        logic [31:0] d;
        d = {b[7:0], 4'hF, 20'((b * 40503 + pass * 977) & 32'hFFFFF)};
        wr(d);
        check("R2 R3 R4 R5 keyed write", rd_data, exp_word(d[19:0]));
      end
    end

    // R6 R8 R9: pulse length and levels across modes, widths and tick rates
    for (int mode = 0; mode < 4; mode++) begin
      wr(mode[0] ? 32'hA5000000 : 32'h5A000000);
      wr(mode[1] ? 32'hA8000000 : 32'h8A000000);
      for (int n = 0; n < 6; n++) begin
        for (int per = 1; per <= 3; per += 2) begin
          wr({12'd0, 20'(n)});
          idle_check(mode[1] ? "R8 idle" : "R9 idle");
          measure(per, len);
          check("R6 length", len, (n + 1) * per);
          idle_check(mode[1] ? "R8 after" : "R9 after");
        end
      end
    end

    // R7 retrigger mid-pulse restarts the count
    wr(32'h00000004);
    trigger = 1'b1;
    step();
    trigger = 1'b0;
    tick = 1'b1;
    repeat (3) step();
    tick = 1'b0;
    measure(1, len);
    check("R7 retrigger", len, 5);

    // R7 trigger and tick in the same cycle: trigger wins
    trigger = 1'b1;
    step();
    tick = 1'b1;
    step();
    trigger = 1'b0;
    len = 0;
    while (asserted() && len < 100) begin len++; step(); end
    tick = 1'b0;
    check("R7 trigger beats tick", len, 5);

    // R6 no ticks: pulse holds
    wr(32'h00000000);
    trigger = 1'b1;
    step();
    trigger = 1'b0;
    repeat (20) step();
    check("R6 hold without tick", {31'd0, asserted()}, 32'd1);
    tick = 1'b1;
    step();
    tick = 1'b0;
    check("R6 end on first tick", {31'd0, asserted()}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule